// File: doc/BRIEF.md
# Single-Bus Hardwired Control Sequencer

This block is a small processor core in which every register transfer crosses one shared internal bus. It holds a sixteen-entry register file, a program counter, an instruction register, a memory address register, a memory data register, an ALU input latch (Y) and an ALU result latch (Z). The ALU adds the bus value to either Y or the constant 4. A hardwired step counter and a combinational decoder choose, for each step, which source drives the bus, which registers load, the ALU function, a memory read request and the end of the instruction.

Every instruction begins with the same three fetch steps. Execute steps follow, chosen by the opcode held in the instruction register. Memory is reached through a single-cycle read request and a completion strobe. The stepper holds on a step marked as a memory wait until completion arrives, so memory latency can vary. The instruction word is 16 bits: opcode in bits [15:12], destination in [11:8], source A in [7:4], source B in [3:0].

Top module: `sbus_core`

## Requirements
- R1: While reset is high and in the first cycle after it, the program counter reads 0, the step number reads 1, and neither the memory request, End nor register write is asserted. Reset loads each register i with the value i.
- R2: In step 1 the program counter is copied to the address register. The cycle after step 1 carries a one-cycle memory request whose address equals the program counter of that instruction.
- R3: The program counter advances by exactly 4 once per instruction, only during step 2. Step 2 repeats until the memory completion strobe is seen.
- R4: The completed fetch word is loaded into the instruction register in step 3. Opcode value 1 selects the register-register add and opcode value 2 selects the indirect add.
- R5: The register-register add writes R[dst] = R[srcA] + R[srcB], modulo 2^16. It takes 6+L cycles from step 1 to End, where L is the fetch latency.
- R6: The indirect add issues a second read at address R[srcA] and writes R[dst] = M[R[srcA]] + R[srcB], modulo 2^16. It takes 7+2L cycles when both reads take L cycles.
- R7: Step 5 of the indirect add repeats until the operand read completes, whatever the latency from 1 to 4 cycles.
- R8: End returns the stepper to step 1 on the next cycle, and the next fetch reads from the advanced program counter.
- R9: Any opcode other than 1 or 2 ends in step 4, after 4+L cycles, with no register write and no further memory read.
- R10: A register write occurs only in the End cycle, exactly once per add instruction. Its index and data are visible on the write-back ports.
- R11: The source registers are read before the destination is written, so a destination equal to a source uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd | output | 1 | One-cycle memory read request |
| mem_addr | output | 16 | Read address (address register contents) |
| mem_rdata | input | 16 | Read data, valid with mem_done |
| mem_done | input | 1 | One-cycle read completion strobe |
| pc_o | output | 16 | Current program counter |
| step_o | output | 3 | Current control step, 1 to 7 |
| end_o | output | 1 | High in the last step of an instruction |
| rf_we | output | 1 | Register file write strobe |
| rf_widx | output | 4 | Register file write index |
| rf_wdata | output | 16 | Register file write data (bus value) |

## Verification
The assertions assume that the memory returns exactly one completion strobe for each request, between one and four cycles after the request cycle, and never without a pending request. The bench memory model arms a single countdown on each request, takes its latency from the test in progress, and never raises a second completion. No request is issued while another is outstanding, so the model never has two requests in flight. The wait-step hold is therefore only checked against a completion that is still due.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int DATA_W   = 16;
    localparam int FIELD_W  = 4;
    localparam int STEP_W   = 3;
    localparam int PC_STEP  = 4;
    localparam int OP_RR    = 1;
    localparam int OP_IND   = 2;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_PC   = 3'd1,
        SRC_Z    = 3'd2,
        SRC_MDR  = 3'd3,
        SRC_RA   = 3'd4,
        SRC_RB   = 3'd5
    } bus_src_e;

    typedef enum logic {
        ALU_PASS = 1'b0,
        ALU_ADD  = 1'b1
    } alu_fn_e;

    typedef struct packed {
        bus_src_e src;
        logic     pc_in;
        logic     mar_in;
        logic     y_in;
        logic     z_in;
        logic     ir_in;
        logic     rf_in;
        logic     sel_four;
        alu_fn_e  alu;
        logic     rd;
        logic     wmfc;
        logic     fin;
    } ctl_t;

    function automatic ctl_t ctl_idle();
        ctl_t c;
        c.src      = SRC_NONE;
        c.pc_in    = 1'b0;
        c.mar_in   = 1'b0;
        c.y_in     = 1'b0;
        c.z_in     = 1'b0;
        c.ir_in    = 1'b0;
        c.rf_in    = 1'b0;
        c.sel_four = 1'b0;
        c.alu      = ALU_PASS;
        c.rd       = 1'b0;
        c.wmfc     = 1'b0;
        c.fin      = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/sbus_stepper.sv
module sbus_stepper #(
    parameter int STEP_W = sbus_pkg::STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fin,
    input  logic              wmfc,
    input  logic              mem_done,
    output logic [STEP_W-1:0] step
);

    localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);

    logic stall;

    assign stall = wmfc && !mem_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= FIRST;
        end else if (fin) begin
            step <= FIRST;
        end else if (!stall) begin
            step <= step + STEP_W'(1);
        end
    end

endmodule

// File: rtl/sbus_decoder.sv
module sbus_decoder
    import sbus_pkg::*;
#(
    parameter int STEP_W  = sbus_pkg::STEP_W,
    parameter int FIELD_W = sbus_pkg::FIELD_W
) (
    input  logic [STEP_W-1:0]  step,
    input  logic [FIELD_W-1:0] opcode,
    output ctl_t               ctl
);

    localparam logic [FIELD_W-1:0] OPC_RR  = FIELD_W'(OP_RR);
    localparam logic [FIELD_W-1:0] OPC_IND = FIELD_W'(OP_IND);

    logic is_rr;
    logic is_ind;

    assign is_rr  = (opcode == OPC_RR);
    assign is_ind = (opcode == OPC_IND);

    always_comb begin
        ctl = ctl_idle();
        case (step)
            STEP_W'(1): begin
                ctl.src      = SRC_PC;
                ctl.mar_in   = 1'b1;
                ctl.rd       = 1'b1;
                ctl.sel_four = 1'b1;
                ctl.alu      = ALU_ADD;
                ctl.z_in     = 1'b1;
            end
            STEP_W'(2): begin
                ctl.src   = SRC_Z;
                ctl.pc_in = 1'b1;
                ctl.y_in  = 1'b1;
                ctl.wmfc  = 1'b1;
            end
            STEP_W'(3): begin
                ctl.src   = SRC_MDR;
                ctl.ir_in = 1'b1;
            end
            STEP_W'(4): begin
                if (is_rr) begin
                    ctl.src  = SRC_RA;
                    ctl.y_in = 1'b1;
                end else if (is_ind) begin
                    ctl.src    = SRC_RA;
                    ctl.mar_in = 1'b1;
                    ctl.rd     = 1'b1;
                end else begin
                    ctl.fin = 1'b1;
                end
            end
            STEP_W'(5): begin
                if (is_rr) begin
                    ctl.src  = SRC_RB;
                    ctl.alu  = ALU_ADD;
                    ctl.z_in = 1'b1;
                end else if (is_ind) begin
                    ctl.src  = SRC_RB;
                    ctl.y_in = 1'b1;
                    ctl.wmfc = 1'b1;
                end else begin
                    ctl.fin = 1'b1;
                end
            end
            STEP_W'(6): begin
                if (is_rr) begin
                    ctl.src   = SRC_Z;
                    ctl.rf_in = 1'b1;
                    ctl.fin   = 1'b1;
                end else if (is_ind) begin
                    ctl.src  = SRC_MDR;
                    ctl.alu  = ALU_ADD;
                    ctl.z_in = 1'b1;
                end else begin
                    ctl.fin = 1'b1;
                end
            end
            STEP_W'(7): begin
                if (is_ind) begin
                    ctl.src   = SRC_Z;
                    ctl.rf_in = 1'b1;
                end
                ctl.fin = 1'b1;
            end
            default: begin
                ctl.fin = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DW      = sbus_pkg::DATA_W,
    parameter int FIELD_W = sbus_pkg::FIELD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  ctl_t               ctl,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_done,
    output logic [FIELD_W-1:0] opcode,
    output logic [DW-1:0]      pc,
    output logic [DW-1:0]      mar,
    output logic               mem_rd,
    output logic [FIELD_W-1:0] dst_idx,
    output logic [DW-1:0]      bus
);

    localparam int NREG  = 1 << FIELD_W;
    localparam int OP_HI = 4 * FIELD_W - 1;
    localparam int RD_HI = 3 * FIELD_W - 1;
    localparam int RA_HI = 2 * FIELD_W - 1;
    localparam int RB_HI = FIELD_W - 1;

    logic [DW-1:0]      ir;
    logic [DW-1:0]      mdr;
    logic [DW-1:0]      y_q;
    logic [DW-1:0]      z_q;
    logic [DW-1:0]      rf [NREG];
    logic [FIELD_W-1:0] ra_idx;
    logic [FIELD_W-1:0] rb_idx;
    logic [DW-1:0]      alu_b;
    logic [DW-1:0]      alu_out;

    assign opcode  = ir[OP_HI -: FIELD_W];
    assign dst_idx = ir[RD_HI -: FIELD_W];
    assign ra_idx  = ir[RA_HI -: FIELD_W];
    assign rb_idx  = ir[RB_HI -: FIELD_W];

    always_comb begin
        case (ctl.src)
            SRC_PC:  bus = pc;
            SRC_Z:   bus = z_q;
            SRC_MDR: bus = mdr;
            SRC_RA:  bus = rf[ra_idx];
            SRC_RB:  bus = rf[rb_idx];
            default: bus = '0;
        endcase
    end

    assign alu_b   = ctl.sel_four ? DW'(PC_STEP) : y_q;
    assign alu_out = (ctl.alu == ALU_ADD) ? (bus + alu_b) : bus;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ir     <= '0;
            mar    <= '0;
            mdr    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            mem_rd <= 1'b0;
        end else begin
            mem_rd <= ctl.rd;
            if (ctl.pc_in)  pc  <= bus;
            if (ctl.ir_in)  ir  <= bus;
            if (ctl.mar_in) mar <= bus;
            if (ctl.y_in)   y_q <= bus;
            if (ctl.z_in)   z_q <= alu_out;
            if (mem_done)   mdr <= mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                rf[i] <= DW'(i);
            end
        end else if (ctl.rf_in) begin
            rf[dst_idx] <= bus;
        end
    end

endmodule

// File: rtl/sbus_core.sv
module sbus_core
    import sbus_pkg::*;
#(
    parameter int DW      = sbus_pkg::DATA_W,
    parameter int FIELD_W = sbus_pkg::FIELD_W,
    parameter int STEP_W  = sbus_pkg::STEP_W
) (
    input  logic               clk,
    input  logic               rst,
    output logic               mem_rd,
    output logic [DW-1:0]      mem_addr,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_done,
    output logic [DW-1:0]      pc_o,
    output logic [STEP_W-1:0]  step_o,
    output logic               end_o,
    output logic               rf_we,
    output logic [FIELD_W-1:0] rf_widx,
    output logic [DW-1:0]      rf_wdata
);

    ctl_t               ctl;
    logic [FIELD_W-1:0] opcode;
    logic [FIELD_W-1:0] dst_idx;
    logic [DW-1:0]      bus;
    logic [STEP_W-1:0]  step;

    sbus_stepper #(.STEP_W(STEP_W)) u_step (
        .clk      (clk),
        .rst      (rst),
        .fin      (ctl.fin),
        .wmfc     (ctl.wmfc),
        .mem_done (mem_done),
        .step     (step)
    );

    sbus_decoder #(.STEP_W(STEP_W), .FIELD_W(FIELD_W)) u_dec (
        .step   (step),
        .opcode (opcode),
        .ctl    (ctl)
    );

    sbus_datapath #(.DW(DW), .FIELD_W(FIELD_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_done  (mem_done),
        .opcode    (opcode),
        .pc        (pc_o),
        .mar       (mem_addr),
        .mem_rd    (mem_rd),
        .dst_idx   (dst_idx),
        .bus       (bus)
    );

    assign step_o   = step;
    assign end_o    = ctl.fin;
    assign rf_we    = ctl.rf_in;
    assign rf_widx  = dst_idx;
    assign rf_wdata = bus;

endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk #(
    parameter int DW     = 16,
    parameter int STEP_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [STEP_W-1:0] step,
    input logic              mem_rd,
    input logic [DW-1:0]     mem_addr,
    input logic              mem_done,
    input logic [DW-1:0]     pc,
    input logic              end_o,
    input logic              rf_we
);

    // R1
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        (step != '0))
        else $error("step left its range");

    // R2
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd)
        else $error("read request longer than one cycle");

    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && step == STEP_W'(2)) |-> (mem_addr == pc))
        else $error("fetch address differs from PC");

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && step == STEP_W'(2)) |=> (pc == $past(pc) + DW'(4)))
        else $error("PC did not advance by 4");

    // R3
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step != STEP_W'(2)) |=> $stable(pc))
        else $error("PC changed outside step 2");

    // R3
    fetch_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_W'(2) && !mem_done) |=> (step == STEP_W'(2)))
        else $error("step 2 left before completion");

    // R8
    end_restart_chk: assert property (@(posedge clk) disable iff (rst)
        end_o |=> (step == STEP_W'(1)))
        else $error("End did not restart the stepper");

    // R10
    wb_end_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> end_o)
        else $error("register write outside the End cycle");

endmodule

bind sbus_core sbus_core_chk #(.DW(DW), .STEP_W(STEP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .step     (step_o),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .mem_done (mem_done),
    .pc       (pc_o),
    .end_o    (end_o),
    .rf_we    (rf_we)
);

// File: tb/tb_sbus_core.sv
`timescale 1ns/1ps
module tb_sbus_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        mem_done = 1'b0;
    logic [15:0] pc_o;
    logic [2:0]  step_o;
    logic        end_o;
    logic        rf_we;
    logic [3:0]  rf_widx;
    logic [15:0] rf_wdata;

    always #2 clk = ~clk;

    sbus_core dut (
        .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_done(mem_done), .pc_o(pc_o),
        .step_o(step_o), .end_o(end_o), .rf_we(rf_we),
        .rf_widx(rf_widx), .rf_wdata(rf_wdata)
    );

    logic [15:0] mem [64];
    int          lat = 1;
    int          cnt = 0;
    logic [5:0]  pend_idx = '0;

    always @(posedge clk) begin
        if (rst) begin
            mem_done <= 1'b0;
            cnt      <= 0;
        end else begin
            mem_done <= 1'b0;
            if (mem_rd) begin
                pend_idx <= mem_addr[7:2];
                if (lat <= 1) begin
                    mem_done  <= 1'b1;
                    mem_rdata <= mem[mem_addr[7:2]];
                end else begin
                    cnt <= lat - 1;
                end
            end else if (cnt > 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    mem_done  <= 1'b1;
                    mem_rdata <= mem[pend_idx];
                end
            end
        end
    end

    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;
    logic [15:0] model_r [16];
    logic [15:0] model_pc;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) model_r[i] = 16'(i);
        model_pc = '0;
        lat = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc_o == 16'h0, "R1", "pc in reset", int'(pc_o), 0);
        chk(step_o == 3'd1, "R1", "step in reset", int'(step_o), 1);
        chk(!mem_rd && !end_o && !rf_we, "R1", "strobes in reset",
            int'({mem_rd, end_o, rf_we}), 0);
        @(posedge clk);
        rst <= 1'b0;
    endtask

    // Runs one instruction starting in its step-1 cycle; checks it fully.
    task automatic do_instr(input logic [15:0] ins, input int l,
                            input string dtag, input string ctag);
        logic [3:0]  op;
        logic [3:0]  d;
        logic [3:0]  a;
        logic [3:0]  b;
        bit          exp_we;
        logic [15:0] exp_data;
        int          exp_cyc;
        int          exp_reads;
        int          cyc;
        int          writes;
        int          reads;
        logic [15:0] addr1;
        logic [15:0] addr2;
        logic [3:0]  got_idx;
        logic [15:0] got_data;
        op = ins[15:12]; d = ins[11:8]; a = ins[7:4]; b = ins[3:0];
        mem[model_pc[7:2]] = ins;
        lat = l;
        exp_we = (op == 4'h1) || (op == 4'h2);
        if (op == 4'h1) begin
            exp_data = model_r[a] + model_r[b];
            exp_cyc = 6 + l;
            exp_reads = 1;
        end else if (op == 4'h2) begin
            exp_data = mem[model_r[a][7:2]] + model_r[b];
            exp_cyc = 7 + 2 * l;
            exp_reads = 2;
        end else begin
            exp_data = '0;
            exp_cyc = 4 + l;
            exp_reads = 1;
        end
        cyc = 0; writes = 0; reads = 0;
        addr1 = '0; addr2 = '0; got_idx = '0; got_data = '0;
        while (cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (mem_rd) begin
                reads++;
                if (reads == 1) addr1 = mem_addr;
                if (reads == 2) addr2 = mem_addr;
            end
            if (rf_we) begin
                writes++;
                got_idx = rf_widx;
                got_data = rf_wdata;
            end
            if (end_o) break;
        end
        chk(cyc == exp_cyc, ctag, "cycles to End", cyc, exp_cyc);
        chk(addr1 == model_pc, "R2", "fetch address", int'(addr1), int'(model_pc));
        chk(reads == exp_reads, exp_we ? "R6" : "R9", "read count", reads, exp_reads);
        if (op == 4'h2)
            chk(addr2 == model_r[a], "R6", "operand address", int'(addr2), int'(model_r[a]));
        chk(writes == (exp_we ? 1 : 0), exp_we ? "R10" : "R9", "write count",
            writes, exp_we ? 1 : 0);
        if (exp_we) begin
            chk(got_idx == d, "R10", "write index", int'(got_idx), int'(d));
            chk(got_data == exp_data, dtag, "write data", int'(got_data), int'(exp_data));
            model_r[d] = exp_data;
        end
        model_pc = model_pc + 16'd4;
        chk(pc_o == model_pc, "R3", "pc after instruction", int'(pc_o), int'(model_pc));
    endtask

    task automatic t_reset_values();
        do_reset();
        do_instr(16'h1312, 1, "R1", "R5");   // 1 + 2 from reset values
        do_instr(16'h1AFE, 2, "R1", "R5");   // 15 + 14
    endtask

    task automatic t_reg_add();
        do_reset();
        do_instr(16'h1736, 4, "R5", "R3");   // fetch waits 4 cycles
        do_instr(16'h1877, 3, "R5", "R5");
        do_instr(16'h1987, 1, "R4", "R4");
    endtask

    task automatic t_indirect();
        do_reset();
        mem[3] = 16'h1234;                   // address 12 = R12 reset value
        do_instr(16'h21C5, 2, "R6", "R6");
        do_instr(16'h22C1, 4, "R6", "R7");
        do_instr(16'h23C2, 1, "R6", "R7");
    endtask

    task automatic t_wrap();
        do_reset();
        mem[3] = 16'hFFFE;
        do_instr(16'h21C5, 3, "R6", "R6");   // 0xFFFE + 5 wraps to 3
        do_instr(16'h1411, 1, "R5", "R5");
        do_instr(16'h2ECC, 2, "R6", "R7");
        do_instr(16'h1FEE, 1, "R5", "R5");
    endtask

    task automatic t_overlap();
        do_reset();
        do_instr(16'h1555, 1, "R11", "R5");  // R5 = 5 + 5
        do_instr(16'h1556, 2, "R11", "R5");
        do_instr(16'h2333, 1, "R11", "R6");  // dst == address == other source
    endtask

    task automatic t_other_opcodes();
        do_reset();
        do_instr(16'h0123, 3, "R9", "R9");
        do_instr(16'hF456, 1, "R9", "R9");
        do_instr(16'h3789, 4, "R9", "R9");
        do_instr(16'h1012, 1, "R9", "R4");   // R1, R2 untouched by the above
    endtask

    task automatic t_back_to_back();
        do_reset();
        for (int k = 0; k < 8; k++) begin
            do_instr({4'h1, 4'(k + 3), 4'(k), 4'(k + 1)}, (k % 4) + 1, "R8", "R8");
        end
    endtask

    initial begin
        t_reset_values();
        t_reg_add();
        t_indirect();
        t_wrap();
        t_overlap();
        t_other_opcodes();
        t_back_to_back();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule